// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block keeps the interrupt status flags of a general-purpose timer that has several channels. Each channel owns a capture/compare flag and an over-capture flag. One more flag records update events. Event pulses arrive from the counter and from the channels. Hardware only ever sets a flag. Software clears flags by writing zeros, and in input mode it can also clear a channel flag by reading that channel's capture register.

Each channel has a direction setting. An input channel raises its flag on a capture. An output channel raises its flag on a compare match, except when the counter runs in center-aligned mode. The over-capture flag records a capture that arrives while the earlier one is still unacknowledged.

The interrupt request is the OR of all flags after each flag has been masked by its own enable bit. This request is registered, so it follows the flags by one cycle.

Top module: `tsf_top`

## Requirements
- R1: After reset every flag bit and the interrupt request are 0.
- R2: The update flag, at bit 2*NUM_CH (bit 8 with four channels), is set by a counter overflow pulse, a counter underflow pulse, a software update request or a slave restart trigger.
- R3: When channel i is in input mode (chIsInput[i]=1), a capture pulse sets the capture/compare flag at bit i.
- R4: When channel i is in input mode, a pulse on capRead[i] clears the flag at bit i. When channel i is in output mode, capRead[i] has no effect.
- R5: The over-capture flag of channel i, at bit NUM_CH+i, is set by a capture in input mode only if the flag at bit i was already 1 before that cycle. The first capture after a clear sets only bit i.
- R6: When channel i is in output mode, a compare match sets bit i while centerMode=0. With centerMode=1 a match does not set it. In output mode a capture pulse sets no flag.
- R7: A write with wrEn=1 clears every flag whose wrData bit is 0 and leaves every flag whose wrData bit is 1 unchanged. A write never sets a flag.
- R8: When a set event and a clear (by write or by read) hit the same flag in the same cycle, the flag ends at 1.
- R9: irq equals the OR over all bits of (flags AND intEnable) as they stood one cycle earlier.
- R10: A flag never goes from 1 to 0 unless a write or a capture read clears it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovfPulse | input | 1 | Counter overflow event |
| udfPulse | input | 1 | Counter underflow event |
| swUpdReq | input | 1 | Software update generation request |
| slvRestart | input | 1 | Restart trigger from the slave trigger input |
| cmpMatch | input | NUM_CH | Per-channel compare match pulse |
| capEvent | input | NUM_CH | Per-channel capture pulse |
| chIsInput | input | NUM_CH | Channel direction: 1 means input (capture), 0 means output (compare) |
| centerMode | input | 1 | Counter is in center-aligned mode |
| wrEn | input | 1 | Write strobe for the flag register |
| wrData | input | 2*NUM_CH+1 | Write data; 0 clears a bit, 1 keeps it |
| capRead | input | NUM_CH | Per-channel capture register read strobe |
| intEnable | input | 2*NUM_CH+1 | Per-flag interrupt enable |
| flags | output | 2*NUM_CH+1 | Flag vector |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check four rules on every cycle. A flag rises only when a set strobe was present, a set strobe always leaves its flag at 1, a flag falls only under a clear strobe, and the request tracks the masked flags one cycle later. A further assertion checks that over-capture only rises while the channel flag was already high. The bench's scenarios are needed to show how the event sources map to bit positions. They also show the direction and center-mode gating, the fact that reads are ignored on output channels, and the write-zero-to-clear convention. A long pseudo-random sweep over all inputs is compared cycle by cycle against an arithmetic model.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  function automatic int flagWidth(input int nCh);
    return 2 * nCh + 1;
  endfunction
  function automatic int ocBase(input int nCh);
    return nCh;
  endfunction
  function automatic int updBit(input int nCh);
    return 2 * nCh;
  endfunction
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl #(
  parameter int NUM_CH = 4,
  parameter type strobe_t = logic,
  localparam int W = tsf_pkg::flagWidth(NUM_CH)
) (
  input  logic              ovfPulse,
  input  logic              udfPulse,
  input  logic              swUpdReq,
  input  logic              slvRestart,
  input  logic [NUM_CH-1:0] cmpMatch,
  input  logic [NUM_CH-1:0] capEvent,
  input  logic [NUM_CH-1:0] chIsInput,
  input  logic              centerMode,
  input  logic              wrEn,
  input  logic [W-1:0]      wrData,
  input  logic [NUM_CH-1:0] capRead,
  input  logic [W-1:0]      flagsQ,
  output strobe_t           strobes
);
  localparam int OC = tsf_pkg::ocBase(NUM_CH);
  localparam int UP = tsf_pkg::updBit(NUM_CH);

  logic [W-1:0] setVec;
  logic [W-1:0] clrVec;
  logic [W-1:0] wrClr;

  assign wrClr = wrEn ? ~wrData : '0;

  always_comb begin
    setVec = '0;
    setVec[UP] = ovfPulse | udfPulse | swUpdReq | slvRestart;
  end

  logic [NUM_CH-1:0] ccSet, ocSet, ccClr;
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ccSet[i] = chIsInput[i] ? capEvent[i] : (cmpMatch[i] & ~centerMode);
    assign ocSet[i] = chIsInput[i] & capEvent[i] & flagsQ[i];
    assign ccClr[i] = wrClr[i] | (chIsInput[i] & capRead[i]);
  end

  always_comb begin
    strobes.setVec = setVec;
    strobes.setVec[NUM_CH-1:0] = ccSet;
    strobes.setVec[OC +: NUM_CH] = ocSet;
    clrVec = wrClr;
    clrVec[NUM_CH-1:0] = ccClr;
    strobes.clrVec = clrVec;
  end
endmodule

// File: rtl/tsf_dp.sv
module tsf_dp #(
  parameter int NUM_CH = 4,
  parameter type strobe_t = logic,
  localparam int W = tsf_pkg::flagWidth(NUM_CH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      strobes,
  input  logic [W-1:0] intEnable,
  output logic [W-1:0] flagsQ,
  output logic         irqQ
);
  logic [W-1:0] flagsNext;

  assign flagsNext = strobes.setVec | (flagsQ & ~strobes.clrVec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      flagsQ <= flagsNext;
      irqQ   <= |(flagsQ & intEnable);
    end
  end

  p_rise_needs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((flagsQ & ~$past(flagsQ) & ~$past(strobes.setVec)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (($past(strobes.setVec) & ~flagsQ) == '0));

  p_fall_needs_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((~flagsQ & $past(flagsQ) & ~$past(strobes.clrVec)) == '0));

  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (irqQ == |($past(flagsQ) & $past(intEnable))));
endmodule

// File: rtl/tsf_top.sv
module tsf_top #(
  parameter int NUM_CH = 4,
  localparam int W = tsf_pkg::flagWidth(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovfPulse,
  input  logic              udfPulse,
  input  logic              swUpdReq,
  input  logic              slvRestart,
  input  logic [NUM_CH-1:0] cmpMatch,
  input  logic [NUM_CH-1:0] capEvent,
  input  logic [NUM_CH-1:0] chIsInput,
  input  logic              centerMode,
  input  logic              wrEn,
  input  logic [W-1:0]      wrData,
  input  logic [NUM_CH-1:0] capRead,
  input  logic [W-1:0]      intEnable,
  output logic [W-1:0]      flags,
  output logic              irq
);
  typedef struct packed {
    logic [W-1:0] setVec;
    logic [W-1:0] clrVec;
  } strobe_t;

  strobe_t      strobes;
  logic [W-1:0] flagsQ;
  logic         irqQ;

  tsf_ctrl #(.NUM_CH(NUM_CH), .strobe_t(strobe_t)) ctrl_i (
    .ovfPulse(ovfPulse), .udfPulse(udfPulse), .swUpdReq(swUpdReq),
    .slvRestart(slvRestart), .cmpMatch(cmpMatch), .capEvent(capEvent),
    .chIsInput(chIsInput), .centerMode(centerMode), .wrEn(wrEn),
    .wrData(wrData), .capRead(capRead), .flagsQ(flagsQ), .strobes(strobes)
  );

  tsf_dp #(.NUM_CH(NUM_CH), .strobe_t(strobe_t)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .intEnable(intEnable),
    .flagsQ(flagsQ), .irqQ(irqQ)
  );

  assign flags = flagsQ;
  assign irq   = irqQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_oc_chk
    p_oc_after_cc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[NUM_CH+i]) |-> $past(flags[i]));
  end
endmodule

// File: tb/tsf_top_tb_top.sv
module tsf_top_tb_top;
  localparam int N = 4;
  localparam int W = 2 * N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovfPulse = 0, udfPulse = 0, swUpdReq = 0, slvRestart = 0;
  logic [N-1:0] cmpMatch = '0, capEvent = '0, chIsInput = '0, capRead = '0;
  logic centerMode = 0, wrEn = 0;
  logic [W-1:0] wrData = '1, intEnable = '1;
  logic [W-1:0] flags;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expFlags = '0;
  logic expIrq = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsf_top #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ovfPulse(ovfPulse), .udfPulse(udfPulse),
    .swUpdReq(swUpdReq), .slvRestart(slvRestart), .cmpMatch(cmpMatch),
    .capEvent(capEvent), .chIsInput(chIsInput), .centerMode(centerMode),
    .wrEn(wrEn), .wrData(wrData), .capRead(capRead), .intEnable(intEnable),
    .flags(flags), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clearInputs();
    ovfPulse = 0; udfPulse = 0; swUpdReq = 0; slvRestart = 0;
    cmpMatch = '0; capEvent = '0; capRead = '0; wrEn = 0; wrData = '1;
  endtask

  // one clock with model comparison; inputs already driven
  task automatic tick();
    logic [W-1:0] setV, clrV, nxt;
    setV = '0;
    clrV = wrEn ? ~wrData : '0;
    setV[2*N] = ovfPulse | udfPulse | swUpdReq | slvRestart;
    for (int i = 0; i < N; i++) begin
      setV[i]   = chIsInput[i] ? capEvent[i] : (cmpMatch[i] & ~centerMode);
      setV[N+i] = chIsInput[i] & capEvent[i] & expFlags[i];
      if (chIsInput[i] & capRead[i]) clrV[i] = 1'b1;
    end
    nxt = setV | (expFlags & ~clrV);
    @(posedge clk);
    @(negedge clk);
    expIrq = |(expFlags & intEnable);
    expFlags = nxt;
    check(flags[2*N] == expFlags[2*N], "R2", flags, expFlags);
    check(flags[2*N-1:N] == expFlags[2*N-1:N], "R5", flags, expFlags);
    check(flags[N-1:0] == expFlags[N-1:0], "R3", flags, expFlags);
    check(irq == expIrq, "R9", irq, expIrq);
    clearInputs();
  endtask

  task automatic clearAll();
    wrEn = 1; wrData = '0; tick();
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check(flags == '0, "R1", flags, 0);
    check(irq == 1'b0, "R1", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: each update source
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: ovfPulse = 1;
        1: udfPulse = 1;
        2: swUpdReq = 1;
        default: slvRestart = 1;
      endcase
      tick();
      check(flags == 9'h100, "R2", flags, 9'h100);
      tick();
      check(irq == 1'b1, "R9", irq, 1);
      wrEn = 1; wrData = 9'h0FF; tick();
      check(flags == '0, "R7", flags, 0);
    end

    // R3/R5/R4 per input channel
    chIsInput = '1;
    for (int c = 0; c < N; c++) begin
      capEvent[c] = 1; tick();
      check(flags == W'(1 << c), "R3", flags, 1 << c);
      capEvent[c] = 1; tick();
      check(flags == W'((1 << c) | (1 << (N + c))), "R5", flags, (1 << c) | (1 << (N + c)));
      capRead[c] = 1; tick();
      check(flags == W'(1 << (N + c)), "R4", flags, 1 << (N + c));
      tick();
      check(flags == W'(1 << (N + c)), "R10", flags, 1 << (N + c));
      wrEn = 1; wrData = ~W'(1 << (N + c)); tick();
      check(flags == '0, "R7", flags, 0);
    end

    // R8: capture and read same cycle, then write-clear with set
    capEvent[1] = 1; capRead[1] = 1; tick();
    check(flags[1] == 1'b1, "R8", flags[1], 1);
    ovfPulse = 1; wrEn = 1; wrData = '0; tick();
    check(flags == 9'h100, "R8", flags, 9'h100);
    wrEn = 1; wrData = '1; tick();
    check(flags == 9'h100, "R7", flags, 9'h100);
    clearAll();

    // R6: output mode compare
    chIsInput = '0;
    cmpMatch[2] = 1; tick();
    check(flags == 9'h004, "R6", flags, 9'h004);
    capRead[2] = 1; tick();
    check(flags == 9'h004, "R4", flags, 9'h004);
    clearAll();
    centerMode = 1; cmpMatch = '1; tick();
    check(flags == '0, "R6", flags, 0);
    centerMode = 0; capEvent = '1; tick();
    check(flags == '0, "R6", flags, 0);

    // R9: enable mask
    intEnable = 9'h0FE; cmpMatch[0] = 1; tick(); tick();
    check(irq == 1'b0, "R9", irq, 0);
    intEnable = 9'h001; tick();
    check(irq == 1'b1, "R9", irq, 1);
    intEnable = '1;
    clearAll();

    // sweep
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ovfPulse = lfsr[0] & lfsr[9];
      udfPulse = lfsr[1] & lfsr[10];
      swUpdReq = lfsr[2] & lfsr[11] & lfsr[5];
      slvRestart = lfsr[3] & lfsr[12] & lfsr[6];
      cmpMatch = lfsr[7:4];
      capEvent = lfsr[11:8] & lfsr[15:12];
      capRead = lfsr[19:16] & lfsr[23:20];
      if (k % 64 == 0) chIsInput = lfsr[27:24];
      centerMode = lfsr[28] & lfsr[29];
      wrEn = lfsr[30] & lfsr[31] & lfsr[3];
      wrData = {lfsr[8:0] | lfsr[20:12]};
      intEnable = (k % 128 < 64) ? '1 : lfsr[31:23];
      tick();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule